// File: doc/BRIEF.md
# Oldest-First Matrix Arbiter

This block chooses one winner per cycle among a set of requesters, always favouring the eligible requester whose previous grant lies furthest in the past. Requesters that have never been granted since reset count as older than any requester that has been granted. Among those never-granted requesters, the lowest index wins. The relative order is kept as a square bit matrix rather than as counters or timestamps. A set bit at row i, column j means that requester i was served more recently than requester j. The chosen requester is the eligible row with the fewest set bits, counted only over eligible columns.

The grant is combinational. It is formed from the request vector and the stored matrix in the same cycle. When a grant is made, the matrix updates at the next rising clock edge: the winner's row is filled with ones, then its column is cleared, so the diagonal stays zero and the winner becomes the youngest. A cycle with no requests leaves the order untouched. When the block is built for exactly two requesters, a single toggle bit that names the older side replaces the matrix. The behaviour at the ports is the same.

Top module: `age_matrix_arbiter`

## Requirements
- R1: After reset the stored order is cleared, so with every requester asserting, the first grant goes to requester 0 (grant vector bit 0), and with no requests the grant is all zeros.
- R2: The grant vector has at most one bit set, that bit is always one of the asserted request bits, and gnt_valid is 1 exactly when at least one request bit is 1.
- R3: The grant goes to the asserted requester whose latest grant is least recent; requesters not granted since reset rank as oldest, and ties among them go to the lowest index.
- R4: A requester granted in one cycle is not granted in the following cycle if any other requester is asserting in that following cycle.
- R5: A cycle with no request bit asserted produces an all-zero grant and gnt_valid 0, and leaves the age order unchanged for later grants.
- R6: The grant reflects the request vector of the same cycle; the age order used for a cycle includes every grant made in earlier cycles.
- R7: A requester that keeps its request asserted is granted within N cycles (at most N-1 cycles of waiting).
- R8: With N = 2, the toggle-bit form gives exactly the grants that R1 to R7 define.
- R9: Asserting reset in the middle of operation returns the order to the post-reset state of R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| req | input | N | Eligibility vector, one bit per requester |
| gnt | output | N | One-hot grant, all zeros when no request is asserted |
| gnt_valid | output | 1 | High when a grant is issued this cycle |

## Verification
The arbiter is first driven with every requester asserting for several full rotations. The grants must then follow strict index order, which separates least-recently-served ordering from any fixed priority. Sparse pseudo-random request patterns then check that rows and columns are counted only over eligible requesters: a requester that was skipped while idle must still rank as old when it returns. Idle cycles placed among requests show that an empty cycle leaves the order frozen. A lone requester held for many cycles shows that it is granted again every cycle when nobody else competes. A two-requester instance runs on the low request bits in parallel and is compared against its own reference order, and a reset mid-stream must bring the order back to index order.

// File: rtl/agearb_pkg.sv
package agearb_pkg;

  // Width of a per-row tally able to hold the values 0..n.
  function automatic int unsigned tally_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/age_bit_matrix.sv
// Storage of relative age: bit [r][c] = 1 means r was served after c.
module age_bit_matrix #(
  parameter int unsigned N = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd_en,
  input  logic [N-1:0]          win_oh,
  output logic [N-1:0][N-1:0]   rows
);

  logic [N-1:0][N-1:0] rows_q;
  logic [N-1:0][N-1:0] rows_d;

  // Next state: winner row filled with ones, then winner column cleared.
  always_comb begin
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        if (win_oh[c]) begin
          rows_d[r][c] = 1'b0;
        end else if (win_oh[r]) begin
          rows_d[r][c] = 1'b1;
        end else begin
          rows_d[r][c] = rows_q[r][c];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rows_q <= '0;
    end else if (upd_en) begin
      rows_q <= rows_d;
    end
  end

  assign rows = rows_q;

endmodule

// File: rtl/age_row_tally.sv
// Counts, for every row, the set bits that fall in eligible columns.
module age_row_tally
  import agearb_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned CW = tally_width(N)
) (
  input  logic [N-1:0][N-1:0]  rows,
  input  logic [N-1:0]         elig,
  output logic [N-1:0][CW-1:0] tally
);

  for (genvar r = 0; r < N; r++) begin : g_row
    logic [N-1:0]  masked;
    logic [CW-1:0] acc;

    assign masked = rows[r] & elig;

    always_comb begin
      acc = '0;
      for (int c = 0; c < N; c++) begin
        acc = acc + CW'(masked[c]);
      end
    end

    assign tally[r] = acc;
  end

endmodule

// File: rtl/age_pick_oldest.sv
// Selects the eligible row with the smallest tally; lowest index on ties.
module age_pick_oldest #(
  parameter int unsigned N  = 8,
  parameter int unsigned CW = 4
) (
  input  logic [N-1:0]         elig,
  input  logic [N-1:0][CW-1:0] tally,
  output logic [N-1:0]         win_oh,
  output logic                 any
);

  logic [CW-1:0] best;
  logic          found;

  always_comb begin
    win_oh = '0;
    best   = '0;
    found  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!found || (tally[i] < best))) begin
        win_oh    = '0;
        win_oh[i] = 1'b1;
        best      = tally[i];
        found     = 1'b1;
      end
    end
  end

  assign any = found;

endmodule

// File: rtl/age_matrix_arbiter.sv
module age_matrix_arbiter
  import agearb_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         gnt_valid
);

  localparam int unsigned CW = tally_width(N);

  if (N == 2) begin : g_pair
    // Single bit naming the older side: 0 -> requester 0 is older.
    logic older_q;
    logic older_d;
    logic upd_en;
    logic [1:0] win;

    always_comb begin
      win[0] = req[0] & (~req[1] | ~older_q);
      win[1] = req[1] & (~req[0] |  older_q);
    end

    assign upd_en  = |req;
    assign older_d = win[0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        older_q <= 1'b0;
      end else if (upd_en) begin
        older_q <= older_d;
      end
    end

    assign gnt       = win;
    assign gnt_valid = upd_en;

  end else begin : g_matrix
    logic [N-1:0][N-1:0]  rows;
    logic [N-1:0][CW-1:0] tally;
    logic [N-1:0]         win_oh;
    logic                 any;

    age_bit_matrix #(.N(N)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd_en (any),
      .win_oh (win_oh),
      .rows   (rows)
    );

    age_row_tally #(.N(N), .CW(CW)) u_tally (
      .rows  (rows),
      .elig  (req),
      .tally (tally)
    );

    age_pick_oldest #(.N(N), .CW(CW)) u_pick (
      .elig   (req),
      .tally  (tally),
      .win_oh (win_oh),
      .any    (any)
    );

    assign gnt       = win_oh;
    assign gnt_valid = any;
  end

endmodule

// File: rtl/age_matrix_arbiter_chk.sv
module age_matrix_arbiter_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req,
  input logic [N-1:0] gnt,
  input logic         gnt_valid
);

  localparam int unsigned WW = $clog2(N + 1) + 1;

  // Per-requester waiting counters, saturating.
  logic [N-1:0][WW-1:0] waitc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waitc <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (req[i] && !gnt[i]) begin
          if (waitc[i] != {WW{1'b1}}) waitc[i] <= waitc[i] + 1'b1;
        end else begin
          waitc[i] <= '0;
        end
      end
    end
  end

  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R2
  gnt_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  // R2
  valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid == (req != '0));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> (gnt == '0));

  // R4
  winner_yields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |=> (($countones(req) < 2) || ((gnt & $past(gnt)) == '0)));

  // R7
  for (genvar i = 0; i < N; i++) begin : g_wait
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      waitc[i] < WW'(N));
  end

endmodule

bind age_matrix_arbiter age_matrix_arbiter_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .gnt       (gnt),
  .gnt_valid (gnt_valid)
);

// File: tb/age_matrix_arbiter_test.sv
`timescale 1ns/1ps
module age_matrix_arbiter_test;

  typedef struct {
    logic [7:0] r;
    logic [7:0] e8;
    logic [1:0] e2;
    string      tag;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic [7:0] req;
  logic [7:0] gnt;
  logic       gnt_valid;
  logic [1:0] gnt2;
  logic       gnt2_valid;

  int checks;
  int errors;
  int stamp;
  int last8 [8];
  int last2 [2];
  int waitn [8];
  bit done;
  exp_t q [$];

  age_matrix_arbiter #(.N(8)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .gnt_valid(gnt_valid)
  );

  age_matrix_arbiter #(.N(2)) uut_pair (
    .clk(clk), .rst_n(rst_n), .req(req[1:0]), .gnt(gnt2), .gnt_valid(gnt2_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 8; i++) last8[i] = -1;
    for (int i = 0; i < 2; i++) last2[i] = -1;
    for (int i = 0; i < 8; i++) waitn[i] = 0;
    stamp = 0;
  endtask

  // Driver: applies a request vector and queues the expected grants.
  task automatic step(input logic [7:0] r, input string tag);
    exp_t e;
    int   w;
    @(negedge clk);
    req  = r;
    e.r  = r;
    e.tag = tag;
    e.e8 = '0;
    e.e2 = '0;
    w = -1;
    for (int i = 0; i < 8; i++)
      if (r[i] && (w < 0 || last8[i] < last8[w])) w = i;
    if (w >= 0) begin e.e8[w] = 1'b1; last8[w] = stamp; end
    w = -1;
    for (int i = 0; i < 2; i++)
      if (r[i] && (w < 0 || last2[i] < last2[w])) w = i;
    if (w >= 0) begin e.e2[w] = 1'b1; last2[w] = stamp; end
    stamp++;
    q.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req   = '0;
    clear_model();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Monitor: pops expected items and compares against the outputs.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(gnt == e.e8, e.tag, gnt, e.e8);
        check(gnt_valid == (e.r != 0), {e.tag, " R2 valid"}, gnt_valid, e.r != 0);
        check(gnt2 == e.e2, {e.tag, " R8 pair"}, gnt2, e.e2);
        check(gnt2_valid == (e.r[1:0] != 0), "R8 pair valid", gnt2_valid, e.r[1:0] != 0);
        for (int i = 0; i < 8; i++) begin
          if (e.r[i]) begin
            if (gnt[i]) begin
              if (waitn[i] > 0) check(waitn[i] < 8, "R7 wait bound", waitn[i], 7);
              waitn[i] = 0;
            end else begin
              waitn[i]++;
            end
          end else begin
            waitn[i] = 0;
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    checks = 0;
    errors = 0;
    done   = 0;
    rst_n  = 1'b0;
    req    = '0;
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: idle after reset, then all requesting: index order from 0.
    step(8'h00, "R1 idle after reset");
    step(8'hFF, "R1 first grant index 0");
    for (int k = 0; k < 23; k++) step(8'hFF, "R3 full rotation");

    // R5: idle cycles keep the order.
    step(8'h00, "R5 idle");
    step(8'h00, "R5 idle");
    step(8'hFF, "R5 order kept");

    // R4: a lone requester is served every cycle; contention forces a change.
    for (int k = 0; k < 5; k++) step(8'h20, "R4 lone requester");
    step(8'h21, "R4 contention");
    step(8'h21, "R4 contention");
    step(8'h21, "R4 contention");

    // R6: request vector changes every cycle.
    step(8'h81, "R6 same-cycle grant");
    step(8'h18, "R6 same-cycle grant");
    step(8'h06, "R6 same-cycle grant");
    step(8'h60, "R6 same-cycle grant");

    // R3: sparse and dense pseudo-random patterns with idle gaps.
    lf = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (k % 3 == 0) step(lf[7:0] & lf[15:8], "R3 sparse");
      else if (k % 17 == 0) step(8'h00, "R5 idle gap");
      else step(lf[7:0] | lf[11:4], "R3 dense");
    end

    // R9: reset mid-stream restores index order.
    step(8'h0F, "R3 before reset");
    step(8'h0F, "R3 before reset");
    do_reset();
    for (int k = 0; k < 10; k++) step(8'hFF, "R9 order after reset");
    step(8'h03, "R8 pair after reset");
    step(8'h03, "R8 pair after reset");

    @(negedge clk);
    req = '0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule